// File: doc/BRIEF.md
# Trip and Release Vote Filter

This block sits behind a protection comparator and turns its per-sample violation flag into a latched trip output. Only clock cycles that carry a sample strobe count as samples. While the output is released, samples that show a violation count toward asserting the trip. While the output is tripped, clean samples count toward releasing it.

Each direction has its own voting policy. Single fires on the first counting sample. Consecutive needs an unbroken run of N counting samples. Majority needs more than half of the last N samples to be counting samples. Every rising edge of the trip also produces a one-clock event pulse.

The two policies and N are held in a configuration register. That register loads only on a synchronous clear, and the clear also empties the run counter and the vote window. In this way a settings change always starts from a clean history.

Top module: `trip_vote_filter`

## Requirements
- R1: After the active-low reset, trip_o and trip_evt_o are low, both policies are single and N is 1, until the first clear.
- R2: The policy encoding is 2'b00 single, 2'b01 consecutive, 2'b10 majority; 2'b11 behaves as single.
- R3: With the single policy, trip_o rises at the clock edge of the first strobed sample with viol_i high.
- R4: With the consecutive policy, trip_o rises at the edge of the N-th strobed violation in an unbroken run; a strobed clean sample restarts the run.
- R5: With the majority policy, trip_o rises at the edge of the strobed sample that makes the violations among the last N samples strictly more than N/2. Only samples taken since the last clear or trip change are counted.
- R6: While trip_o is high, the release policy applies to strobed samples with viol_i low, and trip_o falls when that policy is met.
- R7: Every change of trip_o empties the run count and the vote window, so the opposite direction starts from no history.
- R8: A cycle without strobe_i changes neither trip_o nor any vote history, whatever viol_i is.
- R9: trip_evt_o is high for exactly the one clock in which trip_o has just risen, and stays low when trip_o falls.
- R10: Policies and N are sampled only in a clear_i cycle. The clear empties the history, keeps trip_o, and ignores any strobe in the same cycle. Input changes at any other time have no effect.
- R11: win_len_i of 0 acts as N=1; a value above 16 acts as N=16.
- R12: trip_o and trip_evt_o are registered and change only at the clock edge that takes the deciding sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of history; loads configuration |
| strobe_i | input | 1 | Marks a cycle that carries a sample |
| viol_i | input | 1 | Violation flag of the current sample |
| trip_mode_i | input | 2 | Policy for asserting the trip |
| rel_mode_i | input | 2 | Policy for releasing the trip |
| win_len_i | input | 5 | Window length N, 1 to 16 |
| trip_o | output | 1 | Latched trip |
| trip_evt_o | output | 1 | One-clock pulse on trip rising |

## Verification
Two events can land in the same cycle. A clear can coincide with a strobed violation, and a trip change can coincide with the reset of the vote history that the change itself triggers. The bench drives a clear together with a strobe and a violation, and expects the trip to stay put and the following run to start from zero. It also runs back-to-back trip and release sequences in which the first sample after a flip would meet the policy if stale history survived. A behavioural model built on queues is compared with both outputs after every clock.

// File: rtl/trip_vote_pkg.sv
package trip_vote_pkg;
  typedef enum logic [1:0] {
    VOTE_SINGLE = 2'b00,
    VOTE_RUN    = 2'b01,
    VOTE_MAJ    = 2'b10,
    VOTE_ALT    = 2'b11
  } vote_mode_e;
endpackage

// File: rtl/trip_vote_cfg.sv
module trip_vote_cfg
  import trip_vote_pkg::*;
#(
  parameter int unsigned MAX_WIN = 16,
  parameter int unsigned CW      = $clog2(MAX_WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [1:0]    trip_mode_i,
  input  logic [1:0]    rel_mode_i,
  input  logic [CW-1:0] win_len_i,
  output vote_mode_e    trip_mode_o,
  output vote_mode_e    rel_mode_o,
  output logic [CW-1:0] win_o
);
  localparam logic [CW-1:0] WinMax = CW'(MAX_WIN);

  logic [CW-1:0] win_clamp;

  always_comb begin
    if (win_len_i == '0)          win_clamp = CW'(1);
    else if (win_len_i > WinMax)  win_clamp = WinMax;
    else                          win_clamp = win_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_mode_o <= VOTE_SINGLE;
      rel_mode_o  <= VOTE_SINGLE;
      win_o       <= CW'(1);
    end else if (clear_i) begin
      trip_mode_o <= vote_mode_e'(trip_mode_i);
      rel_mode_o  <= vote_mode_e'(rel_mode_i);
      win_o       <= win_clamp;
    end
  end
endmodule

// File: rtl/trip_vote_run.sv
module trip_vote_run #(
  parameter int unsigned MAX_WIN = 16,
  parameter int unsigned CW      = $clog2(MAX_WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          sample_i,
  input  logic          qual_i,
  input  logic [CW-1:0] win_i,
  output logic          hit_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_inc;

  // saturate so the count cannot wrap when this policy is not selected
  assign cnt_inc = (cnt_o == CW'(MAX_WIN)) ? cnt_o : cnt_o + CW'(1);
  assign hit_o   = sample_i && qual_i && (cnt_inc >= win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (sample_i)  cnt_o <= qual_i ? cnt_inc : '0;
  end
endmodule

// File: rtl/trip_vote_window.sv
module trip_vote_window #(
  parameter int unsigned MAX_WIN = 16,
  parameter int unsigned CW      = $clog2(MAX_WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               sample_i,
  input  logic               qual_i,
  input  logic [CW-1:0]      win_i,
  output logic               hit_o,
  output logic [MAX_WIN-1:0] win_q_o,
  output logic [CW-1:0]      pop_o
);
  logic [MAX_WIN-1:0] keep_mask, last_mask, shifted;
  logic               out_bit;
  logic [CW:0]        pop_nx;
  logic [CW+1:0]      twice_pop, win_ext;

  for (genvar i = 0; i < MAX_WIN; i++) begin : g_mask
    assign keep_mask[i] = (CW'(i) < win_i);
    assign last_mask[i] = (CW'(i) == win_i - CW'(1));
  end

  assign out_bit   = |(win_q_o & last_mask);
  assign shifted   = {win_q_o[MAX_WIN-2:0], qual_i} & keep_mask;
  assign pop_nx    = {1'b0, pop_o} + {{CW{1'b0}}, qual_i} - {{CW{1'b0}}, out_bit};
  assign twice_pop = {pop_nx, 1'b0};
  assign win_ext   = {2'b00, win_i};
  assign hit_o     = sample_i && (twice_pop > win_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q_o <= '0;
      pop_o   <= '0;
    end else if (restart_i) begin
      win_q_o <= '0;
      pop_o   <= '0;
    end else if (sample_i) begin
      win_q_o <= shifted;
      pop_o   <= pop_nx[CW-1:0];
    end
  end
endmodule

// File: rtl/trip_vote_filter.sv
module trip_vote_filter
  import trip_vote_pkg::*;
#(
  parameter int unsigned MAX_WIN = 16,
  localparam int unsigned CW     = $clog2(MAX_WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          strobe_i,
  input  logic          viol_i,
  input  logic [1:0]    trip_mode_i,
  input  logic [1:0]    rel_mode_i,
  input  logic [CW-1:0] win_len_i,
  output logic          trip_o,
  output logic          trip_evt_o
);
  vote_mode_e         trip_mode, rel_mode, act_mode;
  logic [CW-1:0]      win_n, run_cnt, pop_q;
  logic [MAX_WIN-1:0] win_q;
  logic               sample, qual, run_hit, win_hit, flip, restart;

  trip_vote_cfg #(.MAX_WIN(MAX_WIN), .CW(CW)) i_cfg (
    .clk_i, .rst_ni, .clear_i,
    .trip_mode_i, .rel_mode_i, .win_len_i,
    .trip_mode_o (trip_mode),
    .rel_mode_o  (rel_mode),
    .win_o       (win_n)
  );

  assign sample   = strobe_i && !clear_i;
  assign qual     = viol_i ^ trip_o;  // violation counts when released, clean when tripped
  assign act_mode = trip_o ? rel_mode : trip_mode;

  trip_vote_run #(.MAX_WIN(MAX_WIN), .CW(CW)) i_run (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .sample_i  (sample),
    .qual_i    (qual),
    .win_i     (win_n),
    .hit_o     (run_hit),
    .cnt_o     (run_cnt)
  );

  trip_vote_window #(.MAX_WIN(MAX_WIN), .CW(CW)) i_win (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .sample_i  (sample),
    .qual_i    (qual),
    .win_i     (win_n),
    .hit_o     (win_hit),
    .win_q_o   (win_q),
    .pop_o     (pop_q)
  );

  always_comb begin
    unique case (act_mode)
      VOTE_RUN: flip = run_hit;
      VOTE_MAJ: flip = win_hit;
      default:  flip = sample && qual;
    endcase
  end

  assign restart = clear_i || flip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o     <= 1'b0;
      trip_evt_o <= 1'b0;
    end else begin
      trip_o     <= trip_o ^ flip;
      trip_evt_o <= flip && !trip_o;
    end
  end
endmodule

// File: rtl/trip_vote_checker.sv
module trip_vote_checker
  import trip_vote_pkg::*;
#(
  parameter int unsigned MAX_WIN = 16,
  parameter int unsigned CW      = $clog2(MAX_WIN + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               strobe_i,
  input logic               viol_i,
  input logic               trip_o,
  input logic               trip_evt_o,
  input vote_mode_e         act_mode,
  input logic [CW-1:0]      run_cnt,
  input logic [CW-1:0]      pop_q,
  input logic [CW-1:0]      win_n,
  input logic [MAX_WIN-1:0] win_q
);
  assert_evt_on_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_evt_o |-> (trip_o && !$past(trip_o)));

  assert_evt_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_evt_o |=> !trip_evt_o);

  assert_no_strobe_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i || clear_i) |=> $stable(trip_o));

  assert_single_fires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clear_i && viol_i && !trip_o && act_mode == VOTE_SINGLE) |=> trip_o);

  assert_pop_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_q == CW'($countones(win_q)));

  assert_win_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_n >= CW'(1)) && (win_n <= CW'(MAX_WIN)));

  assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CW'(MAX_WIN));

  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (run_cnt == '0 && pop_q == '0));

  assert_flip_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o != $past(trip_o)) |-> (run_cnt == '0 && pop_q == '0));
endmodule

bind trip_vote_filter trip_vote_checker #(.MAX_WIN(MAX_WIN), .CW(CW)) i_chk (
  .clk_i, .rst_ni, .clear_i, .strobe_i, .viol_i, .trip_o, .trip_evt_o,
  .act_mode, .run_cnt, .pop_q, .win_n, .win_q
);

// File: tb/test_trip_vote_filter.sv
module test_trip_vote_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0, strobe_i = 1'b0, viol_i = 1'b0;
  logic [1:0] trip_mode_i = 2'b00, rel_mode_i = 2'b00;
  logic [4:0] win_len_i = 5'd1;
  logic       trip_o, trip_evt_o;

  int checks = 0, errors = 0;
  string req = "R1";

  // reference model state
  int   m_tm = 0, m_rm = 0, m_n = 1, m_run = 0;
  bit   m_trip = 0, m_evt = 0;
  bit   m_hist[$];

  always #5 clk_i = ~clk_i;

  trip_vote_filter i_trip_vote_filter (
    .clk_i, .rst_ni, .clear_i, .strobe_i, .viol_i,
    .trip_mode_i, .rel_mode_i, .win_len_i, .trip_o, .trip_evt_o
  );

  task automatic model_edge();
    int mode, pop;
    bit q, fire;
    m_evt = 0;
    if (clear_i) begin
      m_tm = trip_mode_i;
      m_rm = rel_mode_i;
      m_n  = (win_len_i == 0) ? 1 : (win_len_i > 16) ? 16 : int'(win_len_i);
      m_run = 0;
      m_hist.delete();
    end else if (strobe_i) begin
      q    = m_trip ? !viol_i : viol_i;
      mode = m_trip ? m_rm : m_tm;
      m_run = q ? m_run + 1 : 0;
      m_hist.push_back(q);
      if (m_hist.size() > m_n) void'(m_hist.pop_front());
      pop = 0;
      foreach (m_hist[k]) pop += m_hist[k];
      case (mode)
        1:       fire = (m_run >= m_n);
        2:       fire = (2 * pop > m_n);
        default: fire = q;
      endcase
      if (fire) begin
        m_trip = !m_trip;
        m_evt  = m_trip;
        m_run  = 0;
        m_hist.delete();
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (trip_o !== m_trip || trip_evt_o !== m_evt) begin
      errors++;
      $display("FAIL %s trip/evt got %0b/%0b exp %0b/%0b at %0t",
               req, trip_o, trip_evt_o, m_trip, m_evt, $time);
    end
  endtask

  task automatic step(input bit s, input bit v, input bit c = 0);
    strobe_i = s; viol_i = v; clear_i = c;
    @(posedge clk_i);
    model_edge();
    #2;
    compare();
  endtask

  task automatic load(input int tm, input int rm, input int n);
    trip_mode_i = 2'(tm); rel_mode_i = 2'(rm); win_len_i = 5'(n);
    step(0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    req = "R1"; compare();
    // defaults: single, N=1, no clear yet
    step(1, 1); step(1, 1); step(1, 0);

    req = "R4"; load(1, 1, 3);
    step(1, 1); step(1, 1); step(1, 0); step(1, 1); step(1, 1); step(1, 1);
    req = "R6"; step(1, 0); step(1, 1); step(1, 0); step(1, 0); step(1, 0);

    req = "R5"; load(2, 2, 5);
    step(1, 1); step(1, 0); step(1, 1); step(1, 0); step(1, 1);
    req = "R7"; step(1, 0); step(1, 1); step(1, 0); step(1, 1); step(1, 0); step(1, 0);

    req = "R8"; load(1, 0, 2);
    step(1, 1); step(0, 0); step(0, 1); step(0, 0); step(1, 1);
    step(0, 0); step(0, 0); step(1, 0);

    req = "R10"; load(1, 1, 2);
    step(1, 1); step(1, 1, 1); step(1, 1);
    trip_mode_i = 2'b00; win_len_i = 5'd1; step(1, 0); step(1, 1); step(1, 1);
    step(1, 1, 1); step(1, 0);

    req = "R11"; load(1, 1, 0);
    step(1, 1); step(1, 0);
    load(1, 0, 20);
    for (int i = 0; i < 17; i++) step(1, 1);
    step(1, 0);

    req = "R2"; load(3, 3, 4);
    step(1, 1); step(1, 1); step(1, 0);
    req = "R3"; load(0, 2, 3);
    step(0, 1); step(1, 1); step(1, 0); step(1, 1); step(1, 0);

    req = "R12"; load(2, 1, 1);
    step(1, 1); step(1, 0);

    for (int cfg = 0; cfg < 12; cfg++) begin
      req = "R6";
      load(cfg % 3, (cfg / 3) % 3, 1 + (cfg * 5) % 16);
      for (int i = 0; i < 300; i++)
        step(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 97) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule